// File: doc/BRIEF.md
# Two-Half Issue Queue Steering for Fixed-Point and Load/Store Ops

This block takes one dispatched fixed-point (FX) or load/store (LS) operation per cycle and places it into one of two issue queue halves. Half 0 feeds pipeline set 0 (FX0, LS0, register copy 0). Half 1 feeds pipeline set 1 (FX1, LS1, register copy 1). In four-thread mode the half is fixed by thread pair. In the single- and two-thread modes the register copies are identical, so the block can pick either half. It prefers the half that holds the op's producer, and otherwise it balances occupancy.

Each half keeps its ops in age order. Every cycle it sends its oldest ready FX op to its FX pipe and its oldest ready LS op to its LS pipe. A tag scoreboard records whether each destination tag is in flight, was issued in the previous cycle, or is complete. It also records which half holds the tag's producer. A consumer in the same half as its one-cycle producer issues in the cycle right after the producer. A consumer in the other half waits one more cycle.

Top module: `smt_iq_steer`

## Requirements
- R1: During reset and on the first cycle after it, both halves are empty (occupancy 0), no issue valid is asserted, and a dispatch offered in either mode is accepted.
- R2: In four-thread mode (`mode_quad`=1), threads 0 and 1 are placed in half 0 and threads 2 and 3 in half 1. In other words, `disp_half` equals bit 1 of `disp_tid`, for both FX and LS ops.
- R3: In four-thread mode, `disp_ready` is 0 when the half required by the thread is full, even if the other half has room.
- R4: In flexible mode (`mode_quad`=0), an op with a valid source whose producer tag is still in flight, or was issued in the previous cycle, is placed in the producer's half, whatever the occupancies are.
- R5: In flexible mode, an op with no in-flight producer goes to the half with the lower occupancy, and to half 0 on a tie.
- R6: In flexible mode, if the preferred half is full the op goes to the other half. `disp_ready` is 0 only when both halves are full.
- R7: A consumer placed in the same half as its producer can issue in the cycle right after the cycle in which the producer issues.
- R8: A consumer in the other half from its producer issues no earlier than two cycles after the producer issues.
- R9: In each cycle, each half issues its oldest ready FX op on its FX port and its oldest ready LS op on its LS port, in parallel. The issued tag is the op's destination tag.
- R10: `occ0`/`occ1` give the number of ops held in each half. The count rises by one for an accepted op and falls by one for each op issued, and it never exceeds the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_quad | input | 1 | 1 = four-thread mode (fixed halves), 0 = flexible mode |
| disp_valid | input | 1 | Dispatch op offered this cycle |
| disp_tid | input | 2 | Thread of the op |
| disp_is_ls | input | 1 | 1 = load/store op, 0 = fixed-point op |
| disp_src_vld | input | 1 | Op has a source operand tag |
| disp_src_tag | input | TAG_W | Source operand tag |
| disp_dst_tag | input | TAG_W | Destination tag produced by the op |
| disp_ready | output | 1 | The op offered can be accepted this cycle |
| disp_half | output | 1 | Half chosen for the op offered |
| occ0 | output | $clog2(QDEPTH+1) | Entries held in half 0 |
| occ1 | output | $clog2(QDEPTH+1) | Entries held in half 1 |
| iss_fx_vld | output | 2 | FX issue valid, bit h for half h |
| iss_fx_tag | output | 2*TAG_W | FX issued destination tag, slice h for half h |
| iss_ls_vld | output | 2 | LS issue valid, bit h for half h |
| iss_ls_tag | output | 2*TAG_W | LS issued destination tag, slice h for half h |

## Verification
A scoreboard state that is stuck or wrong shows up in two places. Either a consumer is placed in the wrong half on the next dispatch, or it issues a cycle early or late relative to its producer, within two cycles of the producer issuing. A compaction error in a half shows up on the next cycle. Ops then issue out of age order, tags are dropped or duplicated on the issue ports, or the occupancy count drifts from the number accepted minus the number issued. The bench holds entries in place with self-dependent ops so it can sweep the thread, mode, occupancy and full-queue cases on a four-entry configuration.

// File: rtl/iq_steer_pkg.sv
// Shared types for the two-half issue queue steering block.
// Assumes: tag states are stored per destination tag in the scoreboard.
package iq_steer_pkg;
    // Life cycle of a destination tag
    typedef enum logic [1:0] {
        TS_DONE = 2'd0,   // result available to every half
        TS_JUST = 2'd1,   // issued last cycle: visible to producer's half only
        TS_BUSY = 2'd2    // producer dispatched, not yet issued
    } tag_state_e;
endpackage

// File: rtl/iq_tag_board.sv
// Per-tag scoreboard: tracks whether each destination tag is in flight,
// was issued in the previous cycle, or is complete, plus the half that
// holds its producer. Assumes a tag is not reallocated while in flight.
module iq_tag_board #(
    parameter int TAG_W = 6,
    parameter int NPORT = 4,
    localparam int NTAG = 1 << TAG_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [TAG_W-1:0]            alloc_tag,
    input  logic                        alloc_half,
    input  logic [NPORT-1:0]            iss_vld,
    input  logic [NPORT-1:0][TAG_W-1:0] iss_tag,
    output logic [NTAG-1:0]             done_vec,
    output logic [NTAG-1:0]             just_vec,
    output logic [NTAG-1:0]             home_vec
);
    import iq_steer_pkg::*;

    tag_state_e st_q [NTAG];

    for (genvar t = 0; t < NTAG; t++) begin : g_tag
        logic hit;
        // Does any issue port carry this tag this cycle
        always_comb begin
            hit = 1'b0;
            for (int p = 0; p < NPORT; p++)
                if (iss_vld[p] && iss_tag[p] == TAG_W'(t)) hit = 1'b1;
        end

        // Advance the tag state: allocate, mark issued, then age to done
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[t]     <= TS_DONE;
                home_vec[t] <= 1'b0;
            end else if (alloc_en && alloc_tag == TAG_W'(t)) begin
                st_q[t]     <= TS_BUSY;
                home_vec[t] <= alloc_half;
            end else if (hit) begin
                st_q[t]     <= TS_JUST;
            end else if (st_q[t] == TS_JUST) begin
                st_q[t]     <= TS_DONE;
            end
        end

        assign done_vec[t] = (st_q[t] == TS_DONE);
        assign just_vec[t] = (st_q[t] == TS_JUST);
    end
endmodule

// File: rtl/iq_half_queue.sv
// One issue queue half: an age-ordered, collapsing queue (slot 0 oldest).
// Each cycle it picks the oldest ready FX op and the oldest ready LS op,
// removes them, compacts and appends the new op. Assumes the writer
// never writes when the queue is full.
module iq_half_queue #(
    parameter int DEPTH = 24,
    parameter int TAG_W = 6,
    localparam int NTAG  = 1 << TAG_W,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_ls,
    input  logic             wr_sv,
    input  logic [TAG_W-1:0] wr_src,
    input  logic [TAG_W-1:0] wr_dst,
    input  logic [NTAG-1:0]  done_vec,
    input  logic [NTAG-1:0]  near_vec,
    output logic [OCC_W-1:0] occ,
    output logic             fx_vld,
    output logic [TAG_W-1:0] fx_tag,
    output logic             ls_vld,
    output logic [TAG_W-1:0] ls_tag
);
    typedef struct packed {
        logic             ls;
        logic             sv;
        logic [TAG_W-1:0] src;
        logic [TAG_W-1:0] dst;
    } ent_t;

    ent_t             ent_q [DEPTH];
    ent_t             ent_n [DEPTH];
    logic [OCC_W-1:0] cnt_q, cnt_n;
    logic [DEPTH-1:0] rdy;
    logic [IDX_W-1:0] fx_idx, ls_idx;

    // Operand readiness of each occupied slot
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            rdy[i] = (OCC_W'(i) < cnt_q) &&
                     (!ent_q[i].sv || done_vec[ent_q[i].src] || near_vec[ent_q[i].src]);
    end

    // Oldest-first selection for the FX and LS ports
    always_comb begin
        fx_vld = 1'b0; fx_idx = '0;
        ls_vld = 1'b0; ls_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rdy[i] && !ent_q[i].ls && !fx_vld) begin
                fx_vld = 1'b1; fx_idx = IDX_W'(i);
            end
            if (rdy[i] && ent_q[i].ls && !ls_vld) begin
                ls_vld = 1'b1; ls_idx = IDX_W'(i);
            end
        end
    end

    assign fx_tag = ent_q[fx_idx].dst;
    assign ls_tag = ent_q[ls_idx].dst;
    assign occ    = cnt_q;

    // Compact out the issued slots and append the incoming op
    always_comb begin
        logic [OCC_W-1:0] j;
        j = '0;
        for (int i = 0; i < DEPTH; i++) ent_n[i] = ent_q[i];
        for (int i = 0; i < DEPTH; i++) begin
            if (OCC_W'(i) < cnt_q &&
                !(fx_vld && fx_idx == IDX_W'(i)) &&
                !(ls_vld && ls_idx == IDX_W'(i))) begin
                ent_n[j[IDX_W-1:0]] = ent_q[i];
                j = j + 1'b1;
            end
        end
        if (wr_en && j < OCC_W'(DEPTH)) begin
            ent_n[j[IDX_W-1:0]] = '{ls: wr_ls, sv: wr_sv, src: wr_src, dst: wr_dst};
            j = j + 1'b1;
        end
        cnt_n = j;
    end

    // Register the compacted queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_n;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
        end
    end
endmodule

// File: rtl/iq_half_select.sv
// Steering decision for the op offered this cycle. Four-thread mode: the
// half is bit 1 of the thread ID. Flexible mode: follow an in-flight
// producer, else the less occupied half (tie to half 0), spilling to the
// other half when the preferred one is full.
module iq_half_select #(
    parameter int DEPTH = 24,
    parameter int TAG_W = 6,
    localparam int NTAG  = 1 << TAG_W,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             mode_quad,
    input  logic [1:0]       tid,
    input  logic             src_vld,
    input  logic [TAG_W-1:0] src_tag,
    input  logic [NTAG-1:0]  done_vec,
    input  logic [NTAG-1:0]  home_vec,
    input  logic [OCC_W-1:0] occ0,
    input  logic [OCC_W-1:0] occ1,
    output logic             half,
    output logic             ok
);
    logic full0, full1, pref;

    assign full0 = (occ0 == OCC_W'(DEPTH));
    assign full1 = (occ1 == OCC_W'(DEPTH));

    // Choose the half and whether it can take the op
    always_comb begin
        if (src_vld && !done_vec[src_tag]) pref = home_vec[src_tag];
        else                               pref = (occ1 < occ0);
        if (mode_quad) begin
            half = tid[1];
            ok   = tid[1] ? !full1 : !full0;
        end else begin
            half = (pref ? full1 : full0) ? !pref : pref;
            ok   = !(full0 && full1);
        end
    end
endmodule

// File: rtl/smt_iq_steer.sv
// Top of the two-half FX/LS issue queue steering block. It steers each
// dispatched op into a half, tracks tag state for wakeup, and exposes the
// per-half FX and LS issue ports. Assumes one dispatch per cycle and no
// reuse of a destination tag while its producer is in flight.
module smt_iq_steer #(
    parameter int QDEPTH = 24,
    parameter int TAG_W  = 6,
    localparam int OCC_W = $clog2(QDEPTH + 1),
    localparam int NTAG  = 1 << TAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_quad,
    input  logic               disp_valid,
    input  logic [1:0]         disp_tid,
    input  logic               disp_is_ls,
    input  logic               disp_src_vld,
    input  logic [TAG_W-1:0]   disp_src_tag,
    input  logic [TAG_W-1:0]   disp_dst_tag,
    output logic               disp_ready,
    output logic               disp_half,
    output logic [OCC_W-1:0]   occ0,
    output logic [OCC_W-1:0]   occ1,
    output logic [1:0]         iss_fx_vld,
    output logic [2*TAG_W-1:0] iss_fx_tag,
    output logic [1:0]         iss_ls_vld,
    output logic [2*TAG_W-1:0] iss_ls_tag
);
    logic [NTAG-1:0]       done_vec, just_vec, home_vec;
    logic [OCC_W-1:0]      occ_w [2];
    logic                  accept;
    logic [3:0]            sb_vld;
    logic [3:0][TAG_W-1:0] sb_tag;

    assign occ0   = occ_w[0];
    assign occ1   = occ_w[1];
    assign accept = disp_valid && disp_ready;

    iq_half_select #(.DEPTH(QDEPTH), .TAG_W(TAG_W)) u_sel (
        .mode_quad (mode_quad),
        .tid       (disp_tid),
        .src_vld   (disp_src_vld),
        .src_tag   (disp_src_tag),
        .done_vec  (done_vec),
        .home_vec  (home_vec),
        .occ0      (occ_w[0]),
        .occ1      (occ_w[1]),
        .half      (disp_half),
        .ok        (disp_ready)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        iq_half_queue #(.DEPTH(QDEPTH), .TAG_W(TAG_W)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (accept && (disp_half == 1'(h))),
            .wr_ls    (disp_is_ls),
            .wr_sv    (disp_src_vld),
            .wr_src   (disp_src_tag),
            .wr_dst   (disp_dst_tag),
            .done_vec (done_vec),
            .near_vec (just_vec & ((h == 1) ? home_vec : ~home_vec)),
            .occ      (occ_w[h]),
            .fx_vld   (iss_fx_vld[h]),
            .fx_tag   (iss_fx_tag[h*TAG_W +: TAG_W]),
            .ls_vld   (iss_ls_vld[h]),
            .ls_tag   (iss_ls_tag[h*TAG_W +: TAG_W])
        );
        assign sb_vld[2*h]     = iss_fx_vld[h];
        assign sb_vld[2*h + 1] = iss_ls_vld[h];
        assign sb_tag[2*h]     = iss_fx_tag[h*TAG_W +: TAG_W];
        assign sb_tag[2*h + 1] = iss_ls_tag[h*TAG_W +: TAG_W];
    end

    iq_tag_board #(.TAG_W(TAG_W), .NPORT(4)) u_board (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (accept),
        .alloc_tag  (disp_dst_tag),
        .alloc_half (disp_half),
        .iss_vld    (sb_vld),
        .iss_tag    (sb_tag),
        .done_vec   (done_vec),
        .just_vec   (just_vec),
        .home_vec   (home_vec)
    );
endmodule

// File: rtl/smt_iq_steer_chk.sv
// Property checker for smt_iq_steer, attached with bind.
module smt_iq_steer_chk #(
    parameter int QDEPTH = 24,
    parameter int OCC_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_quad,
    input logic             disp_valid,
    input logic [1:0]       disp_tid,
    input logic             disp_ready,
    input logic             disp_half,
    input logic [OCC_W-1:0] occ0,
    input logic [OCC_W-1:0] occ1,
    input logic [1:0]       iss_fx_vld,
    input logic [1:0]       iss_ls_vld
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (occ0 == '0 && occ1 == '0));

    // R2
    pair_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_quad && disp_valid && disp_ready) |-> (disp_half == disp_tid[1]));

    // R3
    pair_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_quad && disp_tid[1] == 1'b0 && occ0 == OCC_W'(QDEPTH)) |-> !disp_ready);

    // R6
    flex_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_quad && disp_valid && disp_ready && occ0 == OCC_W'(QDEPTH)) |-> disp_half);

    // R10
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ0 <= OCC_W'(QDEPTH)) && (occ1 <= OCC_W'(QDEPTH)));

    // R10
    occ_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && !disp_half && !iss_fx_vld[0] && !iss_ls_vld[0])
        |=> (occ0 == $past(occ0) + 1'b1));
endmodule

bind smt_iq_steer smt_iq_steer_chk #(.QDEPTH(QDEPTH), .OCC_W(OCC_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_quad  (mode_quad),
    .disp_valid (disp_valid),
    .disp_tid   (disp_tid),
    .disp_ready (disp_ready),
    .disp_half  (disp_half),
    .occ0       (occ0),
    .occ1       (occ1),
    .iss_fx_vld (iss_fx_vld),
    .iss_ls_vld (iss_ls_vld)
);

// File: tb/test_smt_iq_steer.sv
// Bench for smt_iq_steer on a four-entry configuration.
module test_smt_iq_steer;
    localparam int D  = 4;
    localparam int TW = 6;
    localparam int OW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_quad = 1'b0;
    logic disp_valid = 1'b0;
    logic [1:0] disp_tid = '0;
    logic disp_is_ls = 1'b0, disp_src_vld = 1'b0;
    logic [TW-1:0] disp_src_tag = '0, disp_dst_tag = '0;
    logic disp_ready, disp_half;
    logic [OW-1:0] occ0, occ1;
    logic [1:0] iss_fx_vld, iss_ls_vld;
    logic [2*TW-1:0] iss_fx_tag, iss_ls_tag;

    int vectors = 0;
    int errors  = 0;

    // captured outputs, sampled mid-cycle
    logic c_rdy, c_half;
    logic [OW-1:0] c_occ0, c_occ1;
    logic [1:0] c_fxv, c_lsv;
    logic [2*TW-1:0] c_fxt, c_lst;

    always #4 clk = ~clk;

    smt_iq_steer #(.QDEPTH(D), .TAG_W(TW)) i_smt_iq_steer (
        .clk(clk), .rst_n(rst_n), .mode_quad(mode_quad),
        .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_is_ls(disp_is_ls),
        .disp_src_vld(disp_src_vld), .disp_src_tag(disp_src_tag),
        .disp_dst_tag(disp_dst_tag), .disp_ready(disp_ready), .disp_half(disp_half),
        .occ0(occ0), .occ1(occ1), .iss_fx_vld(iss_fx_vld), .iss_fx_tag(iss_fx_tag),
        .iss_ls_vld(iss_ls_vld), .iss_ls_tag(iss_ls_tag)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, capture, then pass the rising edge
    task automatic cyc(input logic v, input logic [1:0] tid, input logic ls,
                       input logic sv, input int src, input int dst);
        @(negedge clk);
        disp_valid = v; disp_tid = tid; disp_is_ls = ls; disp_src_vld = sv;
        disp_src_tag = TW'(src); disp_dst_tag = TW'(dst);
        #1;
        c_rdy = disp_ready; c_half = disp_half; c_occ0 = occ0; c_occ1 = occ1;
        c_fxv = iss_fx_vld; c_lsv = iss_ls_vld; c_fxt = iss_fx_tag; c_lst = iss_ls_tag;
        @(posedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, 2'd0, 1'b0, 1'b0, 0, 0);
    endtask

    // Blocking op: depends on its own destination, so it never issues
    task automatic blocker(input logic [1:0] tid, input int tag);
        cyc(1'b1, tid, 1'b0, 1'b1, tag, tag);
    endtask

    task automatic do_reset(input logic quad);
        @(negedge clk);
        rst_n = 1'b0; mode_quad = quad; disp_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b0);
        cyc(1'b1, 2'd0, 1'b0, 1'b0, 0, 40);
        chk("R1 occ0", c_occ0, 0);
        chk("R1 occ1", c_occ1, 0);
        chk("R1 fx issue", c_fxv, 0);
        chk("R1 ls issue", c_lsv, 0);
        chk("R1 ready", c_rdy, 1);

        // R2: four-thread sweep of thread and op type
        do_reset(1'b1);
        for (int t = 0; t < 4; t++)
            for (int l = 0; l < 2; l++) begin
                cyc(1'b1, 2'(t), 1'(l), 1'b0, 0, 30 + 2*t + l);
                chk("R2 half", c_half, t / 2);
                chk("R2 ready", c_rdy, 1);
            end

        // R3: required half full stalls only its pair
        do_reset(1'b1);
        for (int k = 1; k <= D; k++) blocker(2'd0, k);
        cyc(1'b0, 2'd1, 1'b0, 1'b0, 0, 50);
        chk("R3 pair0 stall", c_rdy, 0);
        chk("R10 occ0 full", c_occ0, D);
        cyc(1'b0, 2'd3, 1'b0, 1'b0, 0, 50);
        chk("R3 pair1 open", c_rdy, 1);
        chk("R3 pair1 half", c_half, 1);

        // R5/R6: flexible mode balancing and full stall
        do_reset(1'b0);
        for (int k = 1; k <= 2*D; k++) begin
            cyc(1'b1, 2'd0, 1'b0, 1'b1, k, k);
            chk("R5 balance half", c_half, (k - 1) % 2);
            chk("R6 ready while room", c_rdy, 1);
        end
        cyc(1'b0, 2'd0, 1'b0, 1'b0, 0, 50);
        chk("R6 both full stall", c_rdy, 0);
        chk("R10 occ1 full", c_occ1, D);

        // R4/R6: producer-follow, then spill when producer's half fills
        do_reset(1'b0);
        for (int k = 1; k <= 4; k++) blocker(2'd0, k);
        cyc(1'b1, 2'd0, 1'b0, 1'b1, 1, 9);
        chk("R4 follow producer h0", c_half, 0);
        cyc(1'b1, 2'd0, 1'b0, 1'b1, 2, 10);
        chk("R4 follow producer h1", c_half, 1);
        cyc(1'b1, 2'd0, 1'b0, 1'b1, 1, 11);
        chk("R4 follow over occupancy", c_half, 0);
        chk("R10 occ0 count", c_occ0, 3);
        cyc(1'b1, 2'd0, 1'b0, 1'b1, 1, 12);
        chk("R6 spill to other half", c_half, 1);
        chk("R6 ready on spill", c_rdy, 1);

        // R7/R9: same-half back-to-back, FX producer then LS consumer
        do_reset(1'b0);
        cyc(1'b1, 2'd0, 1'b0, 1'b0, 0, 10);
        cyc(1'b1, 2'd1, 1'b1, 1'b1, 10, 11);
        chk("R4 consumer half", c_half, 0);
        chk("R9 fx issue h0", c_fxv[0], 1);
        chk("R9 fx tag h0", c_fxt[TW-1:0], 10);
        idle();
        chk("R7 back-to-back ls", c_lsv[0], 1);
        chk("R7 ls tag", c_lst[TW-1:0], 11);

        // R8: cross-half consumer waits one extra cycle
        do_reset(1'b1);
        cyc(1'b1, 2'd0, 1'b0, 1'b0, 0, 10);
        cyc(1'b1, 2'd2, 1'b0, 1'b1, 10, 11);
        chk("R8 producer issues", c_fxv[0], 1);
        idle();
        chk("R8 no early cross issue", c_fxv[1], 0);
        idle();
        chk("R8 cross issue", c_fxv[1], 1);
        chk("R8 cross tag", c_fxt[2*TW-1:TW], 11);

        // R9: oldest ready first, FX and LS in parallel
        do_reset(1'b1);
        cyc(1'b1, 2'd0, 1'b0, 1'b0, 0, 20);
        cyc(1'b1, 2'd2, 1'b0, 1'b1, 20, 21);
        cyc(1'b1, 2'd2, 1'b0, 1'b1, 20, 22);
        chk("R9 wait for producer", c_fxv[1], 0);
        cyc(1'b1, 2'd3, 1'b1, 1'b1, 20, 23);
        chk("R9 oldest fx", c_fxt[2*TW-1:TW], 21);
        chk("R9 no ls yet", c_lsv[1], 0);
        idle();
        chk("R9 next fx", c_fxt[2*TW-1:TW], 22);
        chk("R9 parallel ls", c_lsv[1], 1);
        chk("R9 ls tag", c_lst[2*TW-1:TW], 23);
        chk("R10 occ1 before drain", c_occ1, 2);
        idle();
        chk("R10 occ1 drained", c_occ1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule